// File: doc/BRIEF.md
# Receive Staging and Host Burst Writer

This block takes 32-bit quadlets from a link-layer receive stream and holds them in a local staging FIFO that is two cache lines deep. In autonomous mode it works without host involvement. The host posts buffer descriptors ahead of time. Whenever a whole cache line is staged and a descriptor is waiting, the block requests the host bus. It writes the line as one burst of `LINE_Q` beats, then adds a single status beat that carries a running completion count to a fixed location that the host polls. Every transfer to host memory is a write started by this block.

Each descriptor names a buffer by its base address and its length in whole cache lines. The buffer is filled one line per burst, and the descriptor is released when its last line has been written. With no descriptor available the staged data waits, and once staging is full the receive side is stalled. When the mode input selects debug operation, the bus is never requested. The host instead pulses a pull input to admit exactly one line from the link into staging, and then pops the quadlets one at a time through a read port.

Top module: `rxdma_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, `bus_req`, `wr_valid` and `host_rd_valid` are 0. With `dma_en`=1, `rx_ready` and `desc_ready` are 1.
- R2: With `dma_en`=1, quadlets are accepted with no host action for as long as staging (2·`LINE_Q` quadlets) has room.
- R3: `bus_req` rises only when at least `LINE_Q` quadlets are staged and a descriptor is held. With no descriptor, exactly 2·`LINE_Q` quadlets are accepted, then `rx_ready` stays 0 and `bus_req` stays 0.
- R4: After the grant, a burst writes `LINE_Q` beats carrying the staged quadlets in arrival order. Beat k of line n of a buffer goes to base + n·4·`LINE_Q` + 4·k, and `wr_last`=0 on these beats.
- R5: After the last data beat of the same grant comes one status beat to `STAT_ADDR` with `wr_last`=1. Its data is the number of bursts completed since reset, counting this one (1, 2, ...). `bus_req` is 0 in the cycle after the status beat is accepted.
- R6: A descriptor is {`desc_base`, `desc_lines`}, with `desc_lines` ≥ 1. It is used for exactly `desc_lines` consecutive bursts and then released. Descriptors are used in posting order, and no burst goes past the buffer's last line.
- R7: `wr_valid` is high only while `bus_gnt` is high. While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_data` hold.
- R8: With `dma_en`=0, `bus_req` stays 0, and `rx_ready` is 0 until a pull is granted. A granted pull admits exactly `LINE_Q` quadlets.
- R9: A `host_pull` pulse is granted only when staging is empty and no pull is open, and is otherwise ignored. With `dma_en`=0, `host_rd_valid` is 1 while staging holds data, `host_rd_data` is the oldest quadlet, and `host_rd_en` removes it.
- R10: `desc_ready` is 0 exactly when `DESC_DEPTH` descriptors are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | 1 = autonomous burst mode, 0 = host-pull debug mode |
| rx_data | input | 32 | Received quadlet |
| rx_valid | input | 1 | Quadlet offered |
| rx_ready | output | 1 | Quadlet accepted when high with `rx_valid` |
| desc_base | input | 32 | Buffer base address, line aligned |
| desc_lines | input | 8 | Buffer length in cache lines |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor FIFO has room |
| bus_req | output | 1 | Host bus request |
| bus_gnt | input | 1 | Host bus grant |
| wr_addr | output | 32 | Write beat byte address |
| wr_data | output | 32 | Write beat data |
| wr_last | output | 1 | Final (status) beat of the grant |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat taken |
| host_pull | input | 1 | Debug: request one line from the link |
| host_rd_en | input | 1 | Debug: pop the oldest staged quadlet |
| host_rd_data | output | 32 | Debug: oldest staged quadlet |
| host_rd_valid | output | 1 | Debug: staged data present |

## Verification
The embedded checks assume that once `bus_gnt` rises it stays high until `bus_req` falls. They also assume that `dma_en` changes only while no burst is in flight and staging is empty, and that every posted descriptor has a nonzero line count. The stimulus follows these rules. The grant model holds the grant for the whole request, the mode is switched only after every expected write has been observed, and all descriptors carry one to three lines. Within those rules the stimulus varies grant delay and write stalls, and it drives the receive side into a full stall.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int QUAD_W  = 32;
    localparam int ADDR_W  = 32;
    localparam int LINES_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_STAT
    } burst_st_e;

    typedef struct packed {
        logic [LINES_W-1:0] lines;
        logic [ADDR_W-1:0]  base;
    } rx_desc_t;

    function automatic logic [ADDR_W-1:0] line_offset(
        input logic [LINES_W-1:0] idx,
        input int unsigned        line_bytes
    );
        return ADDR_W'(idx) * ADDR_W'(line_bytes);
    endfunction

endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != CW'(DEPTH))); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R9

endmodule

// File: rtl/rxdma_pull_gate.sv
module rxdma_pull_gate #(
    parameter int LINE_Q = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic dma_en,
    input  logic host_pull,
    input  logic stage_empty,
    input  logic rx_fire,
    output logic pull_open
);
    localparam int PW = $clog2(LINE_Q + 1);

    logic [PW-1:0] pull_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_left <= '0;
        end else if (!dma_en && host_pull && pull_left == '0 && stage_empty) begin
            pull_left <= PW'(LINE_Q);
        end else if (rx_fire && pull_left != '0) begin
            pull_left <= pull_left - PW'(1);
        end
    end

    assign pull_open = (pull_left != '0);

    AST_PULL_FROM_HOST: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_open) |-> ($past(host_pull) && $past(stage_empty))); // R9

endmodule

// File: rtl/rxdma_burst_ctrl.sv
module rxdma_burst_ctrl
    import rxdma_pkg::*;
#(
    parameter int              LINE_Q    = 8,
    parameter int              CW        = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h0000_0F00
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dma_en,
    input  logic [CW-1:0]        stage_cnt,
    input  logic [QUAD_W-1:0]    stage_dout,
    output logic                 stage_pop,
    input  logic                 desc_valid,
    input  rx_desc_t             desc,
    output logic                 desc_pop,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [QUAD_W-1:0]    wr_data,
    output logic                 wr_last,
    output logic                 wr_valid,
    input  logic                 wr_ready
);
    localparam int BW         = (LINE_Q > 1) ? $clog2(LINE_Q) : 1;
    localparam int LINE_BYTES = LINE_Q * 4;

    burst_st_e          state;
    logic [BW-1:0]      beat;
    logic [ADDR_W-1:0]  addr;
    logic [LINES_W-1:0] line_idx;
    logic [QUAD_W-1:0]  seq;
    logic               line_ready;
    logic               last_line;

    assign line_ready = dma_en && desc_valid && (stage_cnt >= CW'(LINE_Q));
    assign last_line  = ({1'b0, line_idx} + (LINES_W+1)'(1)) >= {1'b0, desc.lines};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat     <= '0;
            addr     <= '0;
            line_idx <= '0;
            seq      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (line_ready) begin
                        addr  <= desc.base + line_offset(line_idx, LINE_BYTES);
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (bus_gnt) begin
                        beat  <= '0;
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (wr_ready) begin
                        addr <= addr + ADDR_W'(4);
                        beat <= beat + BW'(1);
                        if (beat == BW'(LINE_Q - 1)) state <= ST_STAT;
                    end
                end
                ST_STAT: begin
                    if (wr_ready) begin
                        seq      <= seq + QUAD_W'(1);
                        line_idx <= last_line ? '0 : line_idx + LINES_W'(1);
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (state != ST_IDLE);
        wr_valid  = (state == ST_DATA) || (state == ST_STAT);
        wr_last   = (state == ST_STAT);
        wr_addr   = (state == ST_STAT) ? STAT_ADDR : addr;
        wr_data   = (state == ST_STAT) ? seq + QUAD_W'(1) : stage_dout;
        stage_pop = (state == ST_DATA) && wr_ready;
        desc_pop  = (state == ST_STAT) && wr_ready && last_line;
    end

    AST_REQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> ($past(stage_cnt) >= CW'(LINE_Q) && $past(desc_valid))); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && wr_ready && beat != BW'(LINE_Q - 1))
            |=> (wr_addr == $past(wr_addr) + ADDR_W'(4))); // R4

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_last && wr_ready) |=> !bus_req); // R5

    AST_LINE_IN_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (desc_valid && line_idx < desc.lines)); // R6

    AST_WR_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> bus_gnt); // R7

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7

    AST_DEBUG_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(dma_en)); // R8

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int                LINE_Q      = 8,
    parameter int                STAGE_LINES = 2,
    parameter int                DESC_DEPTH  = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 32'h0000_0F00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dma_en,
    input  logic [QUAD_W-1:0]   rx_data,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [ADDR_W-1:0]   desc_base,
    input  logic [LINES_W-1:0]  desc_lines,
    input  logic                desc_valid,
    output logic                desc_ready,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [QUAD_W-1:0]   wr_data,
    output logic                wr_last,
    output logic                wr_valid,
    input  logic                wr_ready,
    input  logic                host_pull,
    input  logic                host_rd_en,
    output logic [QUAD_W-1:0]   host_rd_data,
    output logic                host_rd_valid
);
    localparam int STAGE_Q = LINE_Q * STAGE_LINES;
    localparam int SCW     = $clog2(STAGE_Q + 1);
    localparam int DCW     = $clog2(DESC_DEPTH + 1);
    localparam int DW      = $bits(rx_desc_t);

    logic [SCW-1:0]    stage_cnt;
    logic              stage_empty;
    logic [QUAD_W-1:0] stage_dout;
    logic              stage_pop, dma_pop, stage_push;
    logic              pull_open;
    logic              rx_fire;

    logic [DCW-1:0]    desc_cnt;
    logic              desc_empty;
    logic              desc_push, desc_pop;
    rx_desc_t          desc_in, desc_head;
    logic [DW-1:0]     desc_head_bits;

    assign rx_ready   = (stage_cnt != SCW'(STAGE_Q)) && (dma_en || pull_open);
    assign rx_fire    = rx_valid && rx_ready;
    assign stage_push = rx_fire;
    assign stage_pop  = dma_en ? dma_pop : (host_rd_en && !stage_empty);

    assign host_rd_valid = !dma_en && !stage_empty;
    assign host_rd_data  = stage_dout;

    assign desc_ready = (desc_cnt != DCW'(DESC_DEPTH));
    assign desc_push  = desc_valid && desc_ready;
    assign desc_in    = '{lines: desc_lines, base: desc_base};
    assign desc_head  = rx_desc_t'(desc_head_bits);

    rxdma_fifo #(.W(QUAD_W), .DEPTH(STAGE_Q)) u_stage (
        .clk   (clk),
        .rst   (rst),
        .push  (stage_push),
        .din   (rx_data),
        .pop   (stage_pop),
        .dout  (stage_dout),
        .count (stage_cnt),
        .empty (stage_empty)
    );

    rxdma_fifo #(.W(DW), .DEPTH(DESC_DEPTH)) u_desc (
        .clk   (clk),
        .rst   (rst),
        .push  (desc_push),
        .din   (desc_in),
        .pop   (desc_pop),
        .dout  (desc_head_bits),
        .count (desc_cnt),
        .empty (desc_empty)
    );

    rxdma_pull_gate #(.LINE_Q(LINE_Q)) u_pull (
        .clk         (clk),
        .rst         (rst),
        .dma_en      (dma_en),
        .host_pull   (host_pull),
        .stage_empty (stage_empty),
        .rx_fire     (rx_fire),
        .pull_open   (pull_open)
    );

    rxdma_burst_ctrl #(.LINE_Q(LINE_Q), .CW(SCW), .STAT_ADDR(STAT_ADDR)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .dma_en     (dma_en),
        .stage_cnt  (stage_cnt),
        .stage_dout (stage_dout),
        .stage_pop  (dma_pop),
        .desc_valid (!desc_empty),
        .desc       (desc_head),
        .desc_pop   (desc_pop),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready)
    );

    AST_DEBUG_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!dma_en && !pull_open) |-> !rx_fire); // R8

    AST_DESC_KEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (desc_cnt == DCW'(DESC_DEPTH) && !desc_pop) |=> (desc_cnt == DCW'(DESC_DEPTH))); // R10

endmodule

// File: tb/tb_rxdma_engine.sv
module tb_rxdma_engine;
    localparam int          LQ   = 8;
    localparam logic [31:0] STAT = 32'h0000_0F00;

    // row: base[63:32] lines[31:24] gnt_delay[23:16] stall[15:8]
    localparam logic [63:0] ROWS [3] = '{
        {32'h0000_1000, 8'd1, 8'd0, 8'd0, 8'd0},
        {32'h0000_2000, 8'd3, 8'd2, 8'd1, 8'd0},
        {32'h0000_3000, 8'd2, 8'd5, 8'd2, 8'd0}
    };

    logic clk = 0, rst = 1, dma_en = 1;
    logic [31:0] rx_data = '0;  logic rx_valid = 0, rx_ready;
    logic [31:0] desc_base = '0; logic [7:0] desc_lines = '0;
    logic desc_valid = 0, desc_ready;
    logic bus_req, bus_gnt = 0;
    logic [31:0] wr_addr, wr_data; logic wr_last, wr_valid, wr_ready = 1;
    logic host_pull = 0, host_rd_en = 0;
    logic [31:0] host_rd_data; logic host_rd_valid;

    int n_tests = 0, n_fail = 0;
    int gnt_delay = 0, stall = 0;
    int qsent = 0, exp_seq = 0;
    int cap_n = 0, viol = 0, total_cyc = 0;
    bit req_seen = 0, dbg_req_seen = 0;
    logic [31:0] cap_addr [64];
    logic [31:0] cap_data [64];
    logic        cap_last [64];
    logic prev_stall = 0; logic [31:0] prev_a, prev_d;

    always #2.5 clk = ~clk;

    rxdma_engine #(.LINE_Q(LQ), .STAGE_LINES(2), .DESC_DEPTH(4), .STAT_ADDR(STAT)) dut (
        .clk(clk), .rst(rst), .dma_en(dma_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .desc_base(desc_base), .desc_lines(desc_lines), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .host_pull(host_pull), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid)
    );

    // grant and write-stall model, updated just after each rising edge
    initial begin
        int cyc = 0, gcnt = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (!bus_req) begin bus_gnt = 0; gcnt = 0; end
            else if (!bus_gnt) begin
                if (gcnt >= gnt_delay) bus_gnt = 1; else gcnt++;
            end
            wr_ready = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) != 0);
        end
    end

    // write-port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req) req_seen = 1;
            if (bus_req && !dma_en) dbg_req_seen = 1;
            if (wr_valid && !bus_gnt) viol++;
            if (prev_stall && (!wr_valid || wr_addr != prev_a || wr_data != prev_d)) viol++;
            prev_stall = wr_valid && !wr_ready;
            prev_a = wr_addr; prev_d = wr_data;
            if (wr_valid && wr_ready && cap_n < 64) begin
                cap_addr[cap_n] = wr_addr; cap_data[cap_n] = wr_data;
                cap_last[cap_n] = wr_last; cap_n++;
            end
        end
    end

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", total_cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic post_desc(input logic [31:0] b, input logic [7:0] l);
        bit ok;
        desc_base = b; desc_lines = l; desc_valid = 1;
        do begin @(negedge clk); ok = desc_ready; @(posedge clk); #1; end while (!ok);
        desc_valid = 0;
    endtask

    task automatic push_quads(input int n, input int limit, output int got);
        bit acc;
        int waited = 0;
        got = 0;
        while (got < n && waited < limit) begin
            rx_valid = 1; rx_data = 32'hC0DE_0000 + qsent;
            @(negedge clk); acc = rx_ready;
            @(posedge clk); #1;
            if (acc) begin got++; qsent++; end
            waited++;
        end
        rx_valid = 0;
    endtask

    task automatic wait_beats(input int n);
        for (int i = 0; i < 3000 && cap_n < n; i++) begin @(posedge clk); #1; end
    endtask

    // one line: LQ data beats then the status beat, starting at capture slot off
    task automatic verify_line(input int off, input logic [31:0] b, input int q0);
        bit ok = 1; logic [31:0] act = '0, exp = '0;
        for (int k = 0; k < LQ; k++) begin
            if (ok && (cap_addr[off+k] != b + 4*k || cap_data[off+k] != 32'hC0DE_0000 + q0 + k
                       || cap_last[off+k])) begin
                ok = 0;
                act = (cap_addr[off+k] != b + 4*k) ? cap_addr[off+k] : cap_data[off+k];
                exp = (cap_addr[off+k] != b + 4*k) ? b + 4*k : 32'hC0DE_0000 + q0 + k;
            end
        end
        check(ok && off + LQ < cap_n, "R4 data beats", act, exp);
        exp_seq++;
        check(cap_addr[off+LQ] == STAT && cap_data[off+LQ] == exp_seq && cap_last[off+LQ] == 1,
              "R5 status beat", cap_data[off+LQ], exp_seq);
    endtask

    initial begin
        int got, q0;
        logic [31:0] b;
        int l;
        tick(4);
        // R1: outputs during reset
        check(bus_req == 0 && wr_valid == 0 && host_rd_valid == 0, "R1 idle in reset", {bus_req, wr_valid, host_rd_valid}, 0);
        rst = 0;
        tick(1);
        check(bus_req == 0 && wr_valid == 0 && host_rd_valid == 0, "R1 idle after reset", {bus_req, wr_valid, host_rd_valid}, 0);
        check(rx_ready == 1 && desc_ready == 1, "R1 ready after reset", {rx_ready, desc_ready}, 2'b11);

        // table walk: R4, R5, R6, R7 under grant delay and write stalls
        for (int r = 0; r < 3; r++) begin
            b = ROWS[r][63:32]; l = ROWS[r][31:24];
            gnt_delay = ROWS[r][23:16]; stall = ROWS[r][15:8];
            cap_n = 0; q0 = qsent;
            post_desc(b, l[7:0]);
            push_quads(l*LQ, 2000, got);
            wait_beats(l*(LQ+1));
            check(cap_n == l*(LQ+1), "R6 bursts per buffer", cap_n, l*(LQ+1));
            for (int n = 0; n < l; n++) verify_line(n*(LQ+1), b + n*4*LQ, q0 + n*LQ);
        end
        tick(4);
        check(viol == 0, "R7 write hold and grant", viol, 0);
        gnt_delay = 1; stall = 0;

        // R3: partial line does not request the bus
        cap_n = 0; req_seen = 0; q0 = qsent;
        post_desc(32'h0000_5000, 8'd1);
        push_quads(5, 50, got);
        tick(20);
        check(req_seen == 0, "R3 no request on partial line", req_seen, 0);
        push_quads(3, 50, got);
        wait_beats(LQ+1);
        verify_line(0, 32'h0000_5000, q0);

        // R2/R3: no descriptor -> staging fills, backpressure, no request
        cap_n = 0; req_seen = 0; q0 = qsent;
        push_quads(3*LQ, 6*LQ, got);
        check(got == 2*LQ, "R2 staged without host action", got, 2*LQ);
        check(rx_ready == 0 && req_seen == 0, "R3 backpressure, no request", {rx_ready, req_seen}, 0);
        post_desc(32'h0000_6000, 8'd2);
        wait_beats(2*(LQ+1));
        verify_line(0, 32'h0000_6000, q0);
        verify_line(LQ+1, 32'h0000_6000 + 4*LQ, q0 + LQ);

        // R10: descriptor FIFO full, then R6 posting order
        cap_n = 0; q0 = qsent;
        for (int d = 0; d < 4; d++) post_desc(32'h0000_7000 + 32'h100*d, 8'd1);
        tick(1);
        check(desc_ready == 0, "R10 full descriptor FIFO", desc_ready, 0);
        push_quads(4*LQ, 1000, got);
        wait_beats(4*(LQ+1));
        for (int d = 0; d < 4; d++) verify_line(d*(LQ+1), 32'h0000_7000 + 32'h100*d, q0 + d*LQ);
        check(desc_ready == 1, "R10 room after release", desc_ready, 1);

        // R8: debug mode closed until a pull
        tick(4);
        dma_en = 0; dbg_req_seen = 0;
        tick(1);
        check(rx_ready == 0, "R8 closed before pull", rx_ready, 0);
        push_quads(4, 10, got);
        check(got == 0 && host_rd_valid == 0, "R8 nothing moves without pull", got, 0);
        q0 = qsent;
        host_pull = 1; tick(1); host_pull = 0;
        push_quads(LQ + 4, 3*LQ, got);
        check(got == LQ, "R8 one line per pull", got, LQ);
        // R9: pull while data staged is ignored
        host_pull = 1; tick(1); host_pull = 0;
        push_quads(2, 10, got);
        check(got == 0, "R9 pull ignored when staged", got, 0);
        for (int k = 0; k < LQ; k++) begin
            check(host_rd_valid == 1 && host_rd_data == 32'hC0DE_0000 + q0 + k, "R9 read order",
                  host_rd_data, 32'hC0DE_0000 + q0 + k);
            host_rd_en = 1; tick(1); host_rd_en = 0;
        end
        check(host_rd_valid == 0, "R9 empty after reads", host_rd_valid, 0);
        check(dbg_req_seen == 0, "R8 no bus request in debug", dbg_req_seen, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule